// File: doc/BRIEF.md
# Multichannel ADC Wake-Up and Capture Sequencer

This controller runs the host side of a multichannel simultaneous-sampling converter that sits on a parallel bus. It holds the converter in shutdown while idle. On a start request it latches three things: a channel-enable mask, the all-on choice and the clock-mode choice. It then releases shutdown and waits out the wake-up time. It writes the mask to the converter and, when all-on is low, fires a throw-away convert-start pulse so that the new mask takes effect. After the settling gap that the clock mode requires, it fires the real convert-start.

Once the converter signals that its last conversion has finished, the controller reads one result per enabled channel, lowest channel first. It presents each result for one cycle with its channel number, then puts the converter back into shutdown. Every wait is a parameterised count of the controller's own clock cycles. The bus is driven only during the write strobe.

Top module: `adc_wake_sequencer`

## Requirements
- R1: During and right after reset, shdn_o is 1, cs_n_o, rd_n_o, wr_n_o and convst_n_o are 1, bus_oe_o is 0 and res_valid_o is 0.
- R2: After a start, the first cycle of the write strobe (wr_n_o low) comes exactly WAKE_CYC + PRE_EXT_CYC cycles after shdn_o falls when ext_clk_i was 1 at start, and WAKE_CYC + PRE_INT_CYC cycles after when it was 0. convst_n_o stays high during that time.
- R3: Each session has exactly one write strobe, lasting WR_CYC cycles with cs_n_o low. During it bus_do carries the latched mask, where bit n enables channel n. bus_oe_o is 1 exactly while wr_n_o is low.
- R4: allon_o equals the all-on value latched at start. With all-on 0 a session makes two convst_n_o low pulses (dummy, then real). With all-on 1 it makes one.
- R5: In external-clock mode with all-on 0, the real convst_n_o fall comes exactly PULSE_CYC + GAP_EXT_CYC cycles after the dummy fall. eoc_n_i is ignored during the gap.
- R6: In internal-clock mode with all-on 0, the real fall comes PULSE_CYC + GAP_INT_CYC cycles after the dummy fall. It comes sooner, one cycle after eoc_n_i is seen low during the gap, if that happens first.
- R7: After eolc_n_i is seen low following the real convert-start, the controller makes as many read strobes as there are 1 bits in the mask. Each strobe holds rd_n_o low for RD_CYC cycles with cs_n_o low and bus_oe_o low.
- R8: res_valid_o pulses for one cycle after the last cycle of each read strobe. res_data_o then holds bus_di as sampled in that last cycle. res_chan_o holds the index of the enabled channel, in ascending order.
- R9: After the last result, shdn_o returns to 1. A start while a session runs is ignored: the mask and modes latched at the first start are kept. A start with an all-zero mask is ignored.
- R10: Every convst_n_o low pulse lasts exactly PULSE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one wake/convert/read session |
| mask_i | input | NCH | Channel-enable mask, bit n = channel n |
| allon_i | input | 1 | All-on choice for the session |
| ext_clk_i | input | 1 | 1 = converter runs on an external clock |
| eoc_n_i | input | 1 | End-of-conversion flag, active low |
| eolc_n_i | input | 1 | End-of-last-conversion flag, active low |
| bus_di | input | DW | Data bus as read from the converter |
| bus_do | output | NCH | Mask value driven on bus lines 0 upward |
| bus_oe_o | output | 1 | Enable for the driven bus lines |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| convst_n_o | output | 1 | Convert start, falling edge starts sampling |
| shdn_o | output | 1 | Shutdown request, high = powered down |
| allon_o | output | 1 | All-on select to the converter |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | DW | Result word |
| res_chan_o | output | $clog2(NCH) | Channel index of the result |

## Verification
The assertions assume that eoc_n_i, eolc_n_i and bus_di are synchronous to clk. They also assume that the converter pulses its flags only some time after a convert-start fall, and that an early end-of-conversion after the dummy pulse arrives only once that pulse has ended. The converter model in the bench changes its outputs on the falling clock edge. It restarts its latency timer on every convert-start fall and uses latencies of at least PULSE_CYC + 1 cycles, so the real conversion's last-conversion flag always lands in the wait state. Start requests while busy, and a zero mask, are driven on purpose to show that they are ignored.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAKE,
        ST_PRE,
        ST_WR,
        ST_DUMMY,
        ST_GAP,
        ST_REAL,
        ST_WAIT,
        ST_READ,
        ST_REC
    } seq_st_e;

    function automatic int cmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R2
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adcseq_lowbit.sv
module adcseq_lowbit #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

    assign any_o = |vec_i;
endmodule

// File: rtl/adc_wake_sequencer.sv
module adc_wake_sequencer
    import adcseq_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int DW          = 14,
    parameter int WAKE_CYC    = 40,
    parameter int PRE_EXT_CYC = 20,
    parameter int PRE_INT_CYC = 8,
    parameter int GAP_EXT_CYC = 15,
    parameter int GAP_INT_CYC = 6,
    parameter int PULSE_CYC   = 2,
    parameter int WR_CYC      = 2,
    parameter int RD_CYC      = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [NCH-1:0]          mask_i,
    input  logic                    allon_i,
    input  logic                    ext_clk_i,
    input  logic                    eoc_n_i,
    input  logic                    eolc_n_i,
    input  logic [DW-1:0]           bus_di,
    output logic [NCH-1:0]          bus_do,
    output logic                    bus_oe_o,
    output logic                    cs_n_o,
    output logic                    rd_n_o,
    output logic                    wr_n_o,
    output logic                    convst_n_o,
    output logic                    shdn_o,
    output logic                    allon_o,
    output logic                    res_valid_o,
    output logic [DW-1:0]           res_data_o,
    output logic [$clog2(NCH)-1:0]  res_chan_o
);
    localparam int CIW  = $clog2(NCH);
    localparam int MAXC = cmax(cmax(cmax(WAKE_CYC, PRE_EXT_CYC), cmax(PRE_INT_CYC, GAP_EXT_CYC)),
                               cmax(cmax(GAP_INT_CYC, PULSE_CYC), cmax(WR_CYC, RD_CYC)));
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] T_WAKE  = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] T_PREX  = CW'(PRE_EXT_CYC - 1);
    localparam logic [CW-1:0] T_PREI  = CW'(PRE_INT_CYC - 1);
    localparam logic [CW-1:0] T_GAPX  = CW'(GAP_EXT_CYC - 1);
    localparam logic [CW-1:0] T_GAPI  = CW'(GAP_INT_CYC - 1);
    localparam logic [CW-1:0] T_PULSE = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] T_WR    = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] T_RD    = CW'(RD_CYC - 1);

    typedef struct packed {
        seq_st_e        st;
        logic [NCH-1:0] mask;
        logic [NCH-1:0] rem;
        logic [CIW-1:0] chan;
        logic           allon;
        logic           ext;
        logic           vld;
        logic [DW-1:0]  data;
    } ctl_t;

    ctl_t           c_d, c_q;
    logic           t_load;
    logic [CW-1:0]  t_val;
    logic           t_zero;
    logic [CIW-1:0] lo_idx;
    logic           lo_any;

    adcseq_timer #(.CW(CW)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .zero_o (t_zero)
    );

    adcseq_lowbit #(.N(NCH), .IW(CIW)) pick_i (
        .vec_i (c_q.rem),
        .idx_o (lo_idx),
        .any_o (lo_any)
    );

    always_comb begin
        c_d     = c_q;
        c_d.vld = 1'b0;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_i && (|mask_i)) begin
                    c_d.mask  = mask_i;
                    c_d.rem   = mask_i;
                    c_d.allon = allon_i;
                    c_d.ext   = ext_clk_i;
                    c_d.st    = ST_WAKE;
                    t_load    = 1'b1;
                    t_val     = T_WAKE;
                end
            end
            ST_WAKE: begin
                if (t_zero) begin
                    c_d.st = ST_PRE;
                    t_load = 1'b1;
                    t_val  = c_q.ext ? T_PREX : T_PREI;
                end
            end
            ST_PRE: begin
                if (t_zero) begin
                    c_d.st = ST_WR;
                    t_load = 1'b1;
                    t_val  = T_WR;
                end
            end
            ST_WR: begin
                if (t_zero) begin
                    c_d.st = c_q.allon ? ST_REAL : ST_DUMMY;
                    t_load = 1'b1;
                    t_val  = T_PULSE;
                end
            end
            ST_DUMMY: begin
                if (t_zero) begin
                    c_d.st = ST_GAP;
                    t_load = 1'b1;
                    t_val  = c_q.ext ? T_GAPX : T_GAPI;
                end
            end
            ST_GAP: begin
                if (t_zero || (!c_q.ext && !eoc_n_i)) begin
                    c_d.st = ST_REAL;
                    t_load = 1'b1;
                    t_val  = T_PULSE;
                end
            end
            ST_REAL: begin
                if (t_zero) c_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (!eolc_n_i) begin
                    c_d.st          = ST_READ;
                    c_d.chan        = lo_idx;
                    c_d.rem[lo_idx] = 1'b0;
                    t_load          = 1'b1;
                    t_val           = T_RD;
                end
            end
            ST_READ: begin
                if (t_zero) begin
                    c_d.vld  = 1'b1;
                    c_d.data = bus_di;
                    c_d.st   = ST_REC;
                end
            end
            ST_REC: begin
                if (lo_any) begin
                    c_d.st          = ST_READ;
                    c_d.chan        = lo_idx;
                    c_d.rem[lo_idx] = 1'b0;
                    t_load          = 1'b1;
                    t_val           = T_RD;
                end else begin
                    c_d.st = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign shdn_o      = (c_q.st == ST_IDLE);
    assign wr_n_o      = (c_q.st != ST_WR);
    assign rd_n_o      = (c_q.st != ST_READ);
    assign cs_n_o      = !((c_q.st == ST_WR) || (c_q.st == ST_READ));
    assign convst_n_o  = !((c_q.st == ST_DUMMY) || (c_q.st == ST_REAL));
    assign bus_oe_o    = (c_q.st == ST_WR);
    assign bus_do      = (c_q.st == ST_WR) ? c_q.mask : '0;
    assign allon_o     = c_q.allon;
    assign res_valid_o = c_q.vld;
    assign res_data_o  = c_q.data;
    assign res_chan_o  = c_q.chan;

    // Checking state for the assertions below
    localparam int SAT  = 2 * MAXC + 2;
    localparam int SW   = $clog2(SAT + 1);
    localparam int HW   = $clog2(WAKE_CYC + cmax(PRE_EXT_CYC, PRE_INT_CYC) + 2);
    logic [CW-1:0]  low_len_q;
    logic           conv_prev_q, rd_prev_q, seen_q;
    logic [SW-1:0]  since_q;
    logic [HW-1:0]  shdn_cnt_q;
    logic [CIW:0]   reads_q;
    logic [CIW-1:0] last_chan_q;
    logic           conv_fall;

    assign conv_fall = conv_prev_q && !convst_n_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len_q   <= '0;
            conv_prev_q <= 1'b1;
            rd_prev_q   <= 1'b1;
            since_q     <= SW'(SAT);
            shdn_cnt_q  <= '0;
            reads_q     <= '0;
            seen_q      <= 1'b0;
            last_chan_q <= '0;
        end else begin
            low_len_q   <= convst_n_o ? '0 : low_len_q + 1'b1;
            conv_prev_q <= convst_n_o;
            rd_prev_q   <= rd_n_o;
            if (conv_fall)                 since_q <= SW'(1);
            else if (since_q < SW'(SAT))   since_q <= since_q + 1'b1;
            if (shdn_o)                                  shdn_cnt_q <= '0;
            else if (shdn_cnt_q != {HW{1'b1}})           shdn_cnt_q <= shdn_cnt_q + 1'b1;
            if (shdn_o)                       reads_q <= '0;
            else if (rd_prev_q && !rd_n_o)    reads_q <= reads_q + 1'b1;
            if (shdn_o) seen_q <= 1'b0;
            else if (res_valid_o) begin
                seen_q      <= 1'b1;
                last_chan_q <= res_chan_o;
            end
        end
    end

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convst_n_o) |-> (low_len_q == CW'(PULSE_CYC)));

    // R5
    ext_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_fall && c_q.st == ST_REAL && !c_q.allon && c_q.ext)
            |-> (since_q >= SW'(PULSE_CYC + GAP_EXT_CYC)));

    // R2
    wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shdn_o && (int'(shdn_cnt_q) < WAKE_CYC + (c_q.ext ? PRE_EXT_CYC : PRE_INT_CYC)))
            |-> (convst_n_o && wr_n_o));

    // R7
    read_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn_o) |-> (int'(reads_q) == $countones(c_q.mask)));

    // R8
    result_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(!rd_n_o));

    // R8
    chan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && seen_q) |-> (res_chan_o > last_chan_q));
endmodule

// File: tb/adc_wake_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_wake_sequencer_tb_top;
    localparam int NCH = 8, DW = 14, WAKE = 40, PREX = 20, PREI = 8;
    localparam int GAPX = 15, GAPI = 6, PUL = 2, WRC = 2, RDC = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           start_i = 1'b0, allon_i = 1'b0, ext_clk_i = 1'b0;
    logic [NCH-1:0] mask_i = '0;
    logic           eoc_n_i = 1'b1, eolc_n_i = 1'b1;
    logic [DW-1:0]  bus_di = '0;
    logic [NCH-1:0] bus_do;
    logic           bus_oe_o, cs_n_o, rd_n_o, wr_n_o, convst_n_o, shdn_o, allon_o;
    logic           res_valid_o;
    logic [DW-1:0]  res_data_o;
    logic [2:0]     res_chan_o;

    adc_wake_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .allon_i(allon_i), .ext_clk_i(ext_clk_i), .eoc_n_i(eoc_n_i),
        .eolc_n_i(eolc_n_i), .bus_di(bus_di), .bus_do(bus_do),
        .bus_oe_o(bus_oe_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
        .convst_n_o(convst_n_o), .shdn_o(shdn_o), .allon_o(allon_o),
        .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_chan_o(res_chan_o)
    );

    int checks = 0, fails = 0;
    int trial = 0, model_lat = 30;

    task automatic chk_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Converter model: reacts on the falling edge
    logic [NCH-1:0] mmask = '0;
    int tmr = 0, ridx = 0;
    logic mp_conv = 1'b1, mp_rd = 1'b1;
    always @(negedge clk) begin
        int n, ch;
        eoc_n_i  = 1'b1;
        eolc_n_i = 1'b1;
        if (mp_conv && !convst_n_o) tmr = model_lat;
        else if (tmr > 0) begin
            tmr--;
            if (tmr == 0) begin
                eoc_n_i  = 1'b0;
                eolc_n_i = 1'b0;
            end
        end
        mp_conv = convst_n_o;
        if (!wr_n_o && bus_oe_o) begin
            mmask = bus_do;
            ridx  = 0;
        end
        if (!mp_rd && rd_n_o) ridx++;
        mp_rd = rd_n_o;
        n = 0; ch = 0;
        for (int c = 0; c < NCH; c++) begin
            if (mmask[c]) begin
                if (n == ridx) ch = c;
                n++;
            end
        end
        bus_di = {3'(ch), 11'(trial)};
    end

    // Port monitor
    int cyc = 0, n_wr = 0, n_conv = 0, n_rd = 0, n_res = 0;
    int bad_oe = 0, bad_cw = 0, bad_rw = 0, bad_cs = 0;
    int t_shdn = 0, t_wr = 0, t_conv = 0, t_rd = 0, gap_last = 0;
    logic allon_seen = 1'b0;
    logic p_shdn = 1'b1, p_wr = 1'b1, p_conv = 1'b1, p_rd = 1'b1;
    int rch [8];
    int rdt [8];
    always @(negedge clk) begin
        cyc++;
        if (p_shdn && !shdn_o) t_shdn = cyc;
        if (p_wr && !wr_n_o) begin
            n_wr++;
            t_wr = cyc;
            allon_seen = allon_o;
        end
        if (!wr_n_o != bus_oe_o) bad_oe++;
        if (!wr_n_o && cs_n_o) bad_oe++;
        if (p_conv && !convst_n_o) begin
            n_conv++;
            gap_last = cyc - t_conv;
            t_conv = cyc;
        end
        if (!p_conv && convst_n_o && (cyc - t_conv != PUL)) bad_cw++;
        if (p_rd && !rd_n_o) begin
            n_rd++;
            t_rd = cyc;
        end
        if (!p_rd && rd_n_o && (cyc - t_rd != RDC)) bad_rw++;
        if (!rd_n_o && (cs_n_o || bus_oe_o)) bad_cs++;
        if (res_valid_o) begin
            rch[n_res % 8] = int'(res_chan_o);
            rdt[n_res % 8] = int'(res_data_o);
            n_res++;
        end
        p_shdn = shdn_o; p_wr = wr_n_o; p_conv = convst_n_o; p_rd = rd_n_o;
    end

    task automatic run(input logic [7:0] m, input logic ext, input logic al, input int lat);
        int b_wr, b_conv, b_rd, b_res, b_oe, b_cw, b_rw, b_cs, j, expg;
        @(negedge clk); #1;
        chk_eq("R9", "idle shdn before start", int'(shdn_o), 1);
        b_wr = n_wr; b_conv = n_conv; b_rd = n_rd; b_res = n_res;
        b_oe = bad_oe; b_cw = bad_cw; b_rw = bad_rw; b_cs = bad_cs;
        model_lat = lat;
        trial++;
        mask_i = m; ext_clk_i = ext; allon_i = al; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        #1;
        mask_i = ~m; allon_i = ~al; ext_clk_i = ~ext; start_i = 1'b1;   // R9: ignored while busy
        @(negedge clk); #1;
        start_i = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk); #1;
            if (shdn_o) break;
        end
        repeat (2) @(negedge clk);
        #1;
        chk_eq("R2", "shdn fall to write", t_wr - t_shdn, WAKE + (ext ? PREX : PREI));
        chk_eq("R3", "write strobes", n_wr - b_wr, 1);
        chk_eq("R3", "mask seen on bus", int'(mmask), int'(m));
        chk_eq("R3", "bus enable errors", bad_oe - b_oe, 0);
        chk_eq("R4", "convst pulses", n_conv - b_conv, al ? 1 : 2);
        chk_eq("R4", "allon output", int'(allon_seen), int'(al));
        if (!al) begin
            if (ext) chk_eq("R5", "dummy to real spacing", gap_last, PUL + GAPX);
            else begin
                expg = (lat + 1 < PUL + GAPI) ? lat + 1 : PUL + GAPI;
                chk_eq("R6", "dummy to real spacing", gap_last, expg);
            end
        end
        chk_eq("R10", "convst width errors", bad_cw - b_cw, 0);
        chk_eq("R7", "read strobes", n_rd - b_rd, $countones(m));
        chk_eq("R7", "read width errors", bad_rw - b_rw, 0);
        chk_eq("R7", "read select errors", bad_cs - b_cs, 0);
        chk_eq("R8", "result count", n_res - b_res, $countones(m));
        j = 0;
        for (int c = 0; c < NCH; c++) begin
            if (m[c] && j < 8) begin
                chk_eq("R8", "result channel", rch[(b_res + j) % 8], c);
                chk_eq("R8", "result data", rdt[(b_res + j) % 8], int'({3'(c), 11'(trial)}));
                j++;
            end
        end
        chk_eq("R9", "shutdown after session", int'(shdn_o), 1);
    endtask

    task automatic zero_mask;
        int b_wr;
        @(negedge clk); #1;
        b_wr = n_wr;
        mask_i = '0; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        repeat (80) @(negedge clk);
        #1;
        chk_eq("R9", "zero mask keeps shutdown", int'(shdn_o), 1);
        chk_eq("R9", "zero mask makes no write", n_wr - b_wr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk_eq("R1", "shdn in reset", int'(shdn_o), 1);
        chk_eq("R1", "strobes in reset", int'({cs_n_o, rd_n_o, wr_n_o, convst_n_o}), 15);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk_eq("R1", "shdn after reset", int'(shdn_o), 1);
        chk_eq("R1", "strobes after reset", int'({cs_n_o, rd_n_o, wr_n_o, convst_n_o}), 15);
        chk_eq("R1", "bus enable after reset", int'(bus_oe_o), 0);
        chk_eq("R1", "valid after reset", int'(res_valid_o), 0);
        zero_mask();
        for (int m = 1; m < 256; m++) run(8'(m), 1'b1, 1'b0, 30);
        for (int m = 1; m < 256; m++) begin
            if (m % 4 == 1 || m == 255) begin
                run(8'(m), 1'b0, 1'b0, 30);
                run(8'(m), 1'b1, 1'b1, 30);
                run(8'(m), 1'b0, 1'b1, 30);
            end
        end
        for (int m = 1; m < 32; m++) begin
            run(8'(m), 1'b0, 1'b0, 3);   // R6: early end-of-conversion
            run(8'(m), 1'b0, 1'b0, 5);
            run(8'(m), 1'b1, 1'b0, 3);   // R5: flag ignored in external mode
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule